// File: doc/BRIEF.md
# Unaligned Vector Edge Loader

This block loads one 128-bit vector register from an address that need not be aligned to 16 bytes. It offers two shaping modes. The leading-edge mode keeps the bytes from the effective address to the end of its 16-byte block and packs them toward the most significant lane. The trailing-edge mode keeps the bytes from the start of the block up to, but not including, the effective address and packs them toward the least significant lane. Every lane that was not loaded is zero.

An operation is presented on a valid/ready handshake together with a base register value, a flag telling whether the base field selects register zero, an index register value, a destination index split into a low and a high field, the mode, and a cache hint. The block adds base and index modulo 2^64, sends a single aligned 16-byte read to memory, and when the big-endian response returns it writes the shaped vector to the register file port in that same cycle. A leading-edge load at EA ORed with a trailing-edge load at EA+16 yields the 16 bytes starting at EA for any alignment.

Top module: `vec_edge_load`

## Requirements
- R1: The effective address is (base_sel == 0 ? 0 : base_val) + index_val, wrapping modulo 2^64, and the memory read address is that value with its low 4 bits cleared.
- R2: In leading-edge mode (mode = 0) with k = EA mod 16, result lane i (lane 0 = bits 127:120) holds the byte at EA + i for i < 16 - k, and lanes 16 - k to 15 are zero.
- R3: In trailing-edge mode (mode = 1), result lane i holds the byte at EA - 16 + i for i >= 16 - k and all other lanes are zero, so k = 0 gives an all-zero result.
- R4: The OR of a leading-edge load at EA and a trailing-edge load at EA + 16 equals the 16 bytes starting at EA, for any k.
- R5: With wide = 1 the destination index is {dst_hi, dst_lo} (7 bits); with wide = 0 it is dst_lo zero-extended.
- R6: The cache hint has no effect on the memory address, result data, index or timing.
- R7: req_ready is high only when idle; an accepted request produces exactly one single-cycle memory request in the next cycle, and requests offered while busy are not accepted.
- R8: rf_we is high for exactly one cycle, the cycle in which mem_rsp_valid is seen after the memory request, and low otherwise.
- R9: After reset, req_ready = 1, mem_req_valid = 0 and rf_we = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Block idle, operation accepted when valid |
| req_mode | input | 1 | 0 leading-edge, 1 trailing-edge |
| req_hint | input | 1 | Cache hint, ignored |
| req_wide | input | 1 | 1 selects the 7-bit destination index |
| req_base_sel | input | 5 | Base register field; 0 means literal zero |
| req_base_val | input | 64 | Contents of the base register |
| req_index_val | input | 64 | Contents of the index register |
| req_dst_lo | input | 5 | Destination index low field |
| req_dst_hi | input | 2 | Destination index high field |
| mem_req_valid | output | 1 | Aligned read request |
| mem_req_addr | output | 64 | Aligned read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 128 | Big-endian block, lowest address in bits 127:120 |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 7 | Register file write index |
| rf_data | output | 128 | Shaped vector |

## Verification
The bench attacks the offset extremes: k = 0, where the leading form must pass the whole block and the trailing form must give zero (a design using 16 - k unguarded would shift by 128 and leak data), and k = 15, where only one byte survives. It checks base field zero with a nonzero register value, which a design reading the register would get wrong by the base value, and an address sum that wraps past 2^64. Leading and trailing results from adjacent blocks are ORed and compared to the unaligned span, catching any off-by-one lane shift, and the narrow index form is checked for stray high bits.

// File: rtl/vel_pkg.sv
package vel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } vel_state_e;

  typedef enum logic {
    MODE_LEAD  = 1'b0,
    MODE_TRAIL = 1'b1
  } vel_mode_e;
endpackage

// File: rtl/vel_addr_gen.sv
module vel_addr_gen #(
  parameter int ADDR_W = 64,
  parameter int SEL_W  = 5,
  parameter int OFF_W  = 4
) (
  input  logic [SEL_W-1:0]  base_sel,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] block_addr,
  output logic [OFF_W-1:0]  offset
);
  // base field of zero stands for the constant zero
  function automatic logic [ADDR_W-1:0] calc_ea(
    input logic [SEL_W-1:0]  sel,
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] x
  );
    logic [ADDR_W-1:0] base;
    base = (sel == '0) ? '0 : b;
    return base + x;
  endfunction

  always_comb begin
    ea         = calc_ea(base_sel, base_val, index_val);
    block_addr = {ea[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    offset     = ea[OFF_W-1:0];
  end
endmodule

// File: rtl/vel_shaper.sv
module vel_shaper #(
  parameter int DATA_BYTES = 16,
  parameter int OFF_W      = 4
) (
  input  logic [8*DATA_BYTES-1:0] blk,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    trail,
  output logic [8*DATA_BYTES-1:0] shaped
);
  localparam int DATA_W = 8 * DATA_BYTES;

  function automatic logic [DATA_W-1:0] shape_lead(
    input logic [DATA_W-1:0] b,
    input logic [OFF_W-1:0]  k
  );
    return b << (8 * int'(k));
  endfunction

  function automatic logic [DATA_W-1:0] shape_trail(
    input logic [DATA_W-1:0] b,
    input logic [OFF_W-1:0]  k
  );
    if (k == '0) return '0;
    return b >> (8 * (DATA_BYTES - int'(k)));
  endfunction

  logic [DATA_W-1:0] lead_v, trail_v;

  always_comb begin
    lead_v  = shape_lead(blk, offset);
    trail_v = shape_trail(blk, offset);
    shaped  = trail ? trail_v : lead_v;
  end
endmodule

// File: rtl/vel_ctrl.sv
module vel_ctrl
  import vel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rsp_valid,
  output logic req_ready,
  output logic accept,
  output logic mem_req_valid,
  output logic rf_we
);
  vel_state_e state_q, state_d;

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    accept        = req_ready && req_valid;
    mem_req_valid = (state_q == ST_REQ);
    rf_we         = (state_q == ST_WAIT) && mem_rsp_valid;
    state_d       = state_q;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = ST_REQ;
      ST_REQ:  state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
  assert_accept_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req_valid);
  assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  assert_we_on_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> mem_rsp_valid);
  assert_we_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !req_ready);
endmodule

// File: rtl/vec_edge_load.sv
module vec_edge_load
  import vel_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_BYTES = 16,
  parameter int SEL_W      = 5,
  parameter int LO_W       = 5,
  parameter int IDX_W      = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_mode,
  input  logic                     req_hint,
  input  logic                     req_wide,
  input  logic [SEL_W-1:0]         req_base_sel,
  input  logic [ADDR_W-1:0]        req_base_val,
  input  logic [ADDR_W-1:0]        req_index_val,
  input  logic [LO_W-1:0]          req_dst_lo,
  input  logic [IDX_W-LO_W-1:0]    req_dst_hi,
  output logic                     mem_req_valid,
  output logic [ADDR_W-1:0]        mem_req_addr,
  input  logic                     mem_rsp_valid,
  input  logic [8*DATA_BYTES-1:0]  mem_rsp_data,
  output logic                     rf_we,
  output logic [IDX_W-1:0]         rf_idx,
  output logic [8*DATA_BYTES-1:0]  rf_data
);
  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int OFF_W  = $clog2(DATA_BYTES);

  logic              accept;
  logic [ADDR_W-1:0] ea_w, block_w;
  logic [OFF_W-1:0]  off_w;
  logic [IDX_W-1:0]  idx_w;

  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;
  vel_mode_e         mode_q;
  logic [IDX_W-1:0]  idx_q;

  vel_addr_gen #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .OFF_W(OFF_W)) u_addr (
    .base_sel  (req_base_sel),
    .base_val  (req_base_val),
    .index_val (req_index_val),
    .ea        (ea_w),
    .block_addr(block_w),
    .offset    (off_w)
  );

  vel_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .mem_rsp_valid(mem_rsp_valid),
    .req_ready    (req_ready),
    .accept       (accept),
    .mem_req_valid(mem_req_valid),
    .rf_we        (rf_we)
  );

  vel_shaper #(.DATA_BYTES(DATA_BYTES), .OFF_W(OFF_W)) u_shape (
    .blk   (mem_rsp_data),
    .offset(off_q),
    .trail (mode_q == MODE_TRAIL),
    .shaped(rf_data)
  );

  // destination index: extended form concatenates both fields
  generate
    if (IDX_W > LO_W) begin : g_wide_idx
      assign idx_w = req_wide ? {req_dst_hi, req_dst_lo}
                              : {{(IDX_W-LO_W){1'b0}}, req_dst_lo};
    end else begin : g_narrow_idx
      assign idx_w = req_dst_lo[IDX_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      off_q  <= '0;
      mode_q <= MODE_LEAD;
      idx_q  <= '0;
    end else if (accept) begin
      addr_q <= block_w;
      off_q  <= off_w;
      mode_q <= vel_mode_e'(req_mode);
      idx_q  <= idx_w;
    end
  end

  assign mem_req_addr = addr_q;
  assign rf_idx       = idx_q;

  function automatic logic [DATA_W-1:0] low_mask(input logic [OFF_W-1:0] k);
    return ({{(DATA_W-1){1'b0}}, 1'b1} << (8 * int'(k))) - 1'b1;
  endfunction

  assert_addr_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
  assert_lead_tail_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && mode_q == MODE_LEAD) |-> ((rf_data & low_mask(off_q)) == '0));
  assert_trail_k0_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && mode_q == MODE_TRAIL && off_q == '0) |-> (rf_data == '0));
  assert_idx_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> $stable(rf_idx));
  assert_hint_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_hint) |=> mem_req_valid);
endmodule

// File: tb/vec_edge_load_tb_top.sv
module vec_edge_load_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_mode = 1'b0;
  logic         req_hint = 1'b0;
  logic         req_wide = 1'b0;
  logic [4:0]   req_base_sel = '0;
  logic [63:0]  req_base_val = '0;
  logic [63:0]  req_index_val = '0;
  logic [4:0]   req_dst_lo = '0;
  logic [1:0]   req_dst_hi = '0;
  logic         mem_req_valid;
  logic [63:0]  mem_req_addr;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_data = '0;
  logic         rf_we;
  logic [6:0]   rf_idx;
  logic [127:0] rf_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  vec_edge_load dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_hint(req_hint), .req_wide(req_wide),
    .req_base_sel(req_base_sel), .req_base_val(req_base_val),
    .req_index_val(req_index_val), .req_dst_lo(req_dst_lo),
    .req_dst_hi(req_dst_hi), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_data(rf_data)
  );

  typedef struct packed {
    logic        mode;
    logic        hint;
    logic        wide;
    logic [4:0]  sel;
    logic [63:0] base;
    logic [63:0] index;
    logic [1:0]  hi;
    logic [4:0]  lo;
    logic [6:0]  exp_idx;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    '{1'b0, 1'b0, 1'b1, 5'd3, 64'h1000, 64'h0,   2'd2, 5'd5,  7'h45},
    '{1'b0, 1'b0, 1'b1, 5'd3, 64'h1000, 64'h7,   2'd1, 5'd31, 7'h3F},
    '{1'b0, 1'b1, 1'b0, 5'd4, 64'h2000, 64'hF,   2'd3, 5'd9,  7'h09},
    '{1'b1, 1'b0, 1'b1, 5'd1, 64'h3000, 64'h0,   2'd3, 5'd0,  7'h60},
    '{1'b1, 1'b0, 1'b1, 5'd2, 64'h3000, 64'h5,   2'd0, 5'd1,  7'h01},
    '{1'b1, 1'b1, 1'b1, 5'd0, 64'hDEAD, 64'h40C, 2'd1, 5'd2,  7'h22},
    '{1'b0, 1'b0, 1'b1, 5'd0, 64'hBEEF, 64'h123, 2'd0, 5'd0,  7'h00},
    '{1'b1, 1'b0, 1'b0, 5'd5, 64'hFFFF_FFFF_FFFF_FFF8, 64'h11, 2'd2, 5'd30, 7'h1E}
  };

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [127:0] mem_block(input logic [63:0] a);
    logic [127:0] r;
    for (int j = 0; j < 16; j++) r[127-8*j -: 8] = mbyte(a + 64'(j));
    return r;
  endfunction

  function automatic logic [127:0] exp_result(input logic mode, input logic [63:0] ea);
    logic [127:0] r;
    int k;
    k = int'(ea[3:0]);
    r = '0;
    for (int i = 0; i < 16; i++) begin
      if (!mode && i < 16 - k) r[127-8*i -: 8] = mbyte(ea + 64'(i));
      if (mode && i >= 16 - k) r[127-8*i -: 8] = mbyte(ea - 64'd16 + 64'(i));
    end
    return r;
  endfunction

  function automatic logic [127:0] span(input logic [63:0] ea);
    logic [127:0] r;
    for (int i = 0; i < 16; i++) r[127-8*i -: 8] = mbyte(ea + 64'(i));
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [63:0]  got_addr;
  logic [127:0] got_data;
  logic [6:0]   got_idx;

  task automatic run_op(input logic mode, input logic hint, input logic wide,
                        input logic [4:0] sel, input logic [63:0] base,
                        input logic [63:0] index, input logic [1:0] hi,
                        input logic [4:0] lo, input bit poke);
    logic wev;
    @(negedge clk);
    req_mode = mode; req_hint = hint; req_wide = wide; req_base_sel = sel;
    req_base_val = base; req_index_val = index; req_dst_hi = hi; req_dst_lo = lo;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R7 ready idle", 128'(req_ready), 128'd1);
    @(negedge clk);
    if (!poke) req_valid = 1'b0;
    else begin req_mode = ~mode; req_base_val = base + 64'h100; end
    chk(mem_req_valid == 1'b1, "R7 mem req", 128'(mem_req_valid), 128'd1);
    chk(rf_we == 1'b0, "R8 no early we", 128'(rf_we), 128'd0);
    got_addr = mem_req_addr;
    @(negedge clk);
    chk(mem_req_valid == 1'b0 && req_ready == 1'b0, "R7 single req busy",
        128'({mem_req_valid, req_ready}), 128'd0);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = mem_block(got_addr);
    #1;
    wev = rf_we; got_data = rf_data; got_idx = rf_idx;
    chk(wev == 1'b1, "R8 we on rsp", 128'(wev), 128'd1);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    req_valid = 1'b0;
    chk(rf_we == 1'b0 && req_ready == 1'b1 && mem_req_valid == 1'b0,
        "R8 we single cycle", 128'({rf_we, req_ready, mem_req_valid}), 128'b010);
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [63:0]  ea;
    logic [127:0] lead_d, h0, h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1 && mem_req_valid == 1'b0 && rf_we == 1'b0, "R9 reset",
        128'({req_ready, mem_req_valid, rf_we}), 128'b100);

    foreach (TABLE[n]) begin
      vec_t v;
      v = TABLE[n];
      run_op(v.mode, v.hint, v.wide, v.sel, v.base, v.index, v.hi, v.lo, 1'b0);
      ea = ((v.sel == 5'd0) ? 64'd0 : v.base) + v.index;
      chk(got_addr == {ea[63:4], 4'h0}, "R1 aligned addr", 128'(got_addr),
          128'({ea[63:4], 4'h0}));
      chk(got_data == exp_result(v.mode, ea), v.mode ? "R3 trail shape" : "R2 lead shape",
          got_data, exp_result(v.mode, ea));
      chk(got_idx == v.exp_idx, "R5 dst index", 128'(got_idx), 128'(v.exp_idx));
    end

    // R4 lead at EA OR trail at EA+16 gives the unaligned span
    for (int k = 0; k < 16; k += 5) begin
      ea = 64'h5000 + 64'(k);
      run_op(1'b0, 1'b0, 1'b1, 5'd7, 64'h5000, 64'(k), 2'd0, 5'd3, 1'b0);
      lead_d = got_data;
      run_op(1'b1, 1'b0, 1'b1, 5'd7, 64'h5000, 64'(k + 16), 2'd0, 5'd4, 1'b0);
      chk((lead_d | got_data) == span(ea), "R4 combined span", lead_d | got_data, span(ea));
    end

    // R6 hint has no effect
    run_op(1'b0, 1'b0, 1'b1, 5'd2, 64'h7000, 64'h9, 2'd1, 5'd1, 1'b0);
    h0 = got_data;
    run_op(1'b0, 1'b1, 1'b1, 5'd2, 64'h7000, 64'h9, 2'd1, 5'd1, 1'b0);
    h1 = got_data;
    chk(h0 == h1, "R6 hint data", h1, h0);

    // R3 trailing with k=0 yields zero
    run_op(1'b1, 1'b0, 1'b1, 5'd1, 64'h8000, 64'h0, 2'd0, 5'd0, 1'b0);
    chk(got_data == '0, "R3 trail k0 zero", got_data, '0);

    // R7 requests offered while busy are not taken
    run_op(1'b0, 1'b0, 1'b1, 5'd1, 64'h9000, 64'h4, 2'd0, 5'd6, 1'b1);
    chk(got_data == exp_result(1'b0, 64'h9004), "R7 busy request ignored",
        got_data, exp_result(1'b0, 64'h9004));
    @(negedge clk);
    chk(mem_req_valid == 1'b0, "R7 no extra access", 128'(mem_req_valid), 128'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule